// File: doc/BRIEF.md
# Supervisory Reset Controller with Strobe Watchdog

This block supervises a processor subsystem and drives one reset signal as a complementary pair: one output active high, the other active low. Four conditions request reset. The first is a synchronous power-on input. The second is a supply-fail flag that arrives already digitised. The third is an active-low push-button that is debounced inside the block. The fourth is a watchdog that must see falling edges on a strobe line.

All requests feed a single stretch timer. Reset stays asserted while any request is active. After the last request clears, reset holds for a fixed stretch period and then releases.

Every period is given in milliseconds and turned into clock cycles at elaboration through a cycles-per-millisecond parameter. A scaled clock can therefore be used in tests. A two-bit select picks one of three watchdog periods at run time. The watchdog does not count while reset is asserted, so its first period starts when reset releases. The strobe and push-button inputs each pass through a two-flop synchronizer first.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `por_i` is high, `rst_o` is high from the next cycle on. After `por_i` falls, reset remains asserted for the stretch period.
- R2: `rst_n_o` is always the logical inverse of `rst_o`.
- R3: `supply_fail_i` high at a clock edge makes `rst_o` high in the following cycle.
- R4: The push-button `pb_n_i` is active low.
  - A low of `DEBOUNCE_MS` (default 4 ms) or more, plus two synchronizer cycles, asserts reset.
  - Any low of 1 ms or less is ignored.
  - The delay from button to reset never exceeds 20 ms.
- R5: After the last reset cause clears, `rst_o` stays high for `STRETCH_MS` (610 ms) and then falls.
- R6: When no strobe falling edge arrives, the watchdog asserts reset one timeout after reset released. The timeout depends on `wd_sel_i`:
  - 2'b00 gives 150 ms.
  - 2'b01 gives 600 ms.
  - 2'b10 and 2'b11 both give 1200 ms.
- R7: Only a high-to-low transition of `strobe_i` restarts the watchdog. A strobe held steady high or low times out. Falling edges spaced closer than the timeout keep reset released.
- R8: The watchdog count is held at zero while reset is asserted. A watchdog expiry clears the count and starts the stretch.
- R9: A change of `wd_sel_i` restarts the watchdog count. The new timeout is measured from the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of known frequency |
| por_i | input | 1 | Synchronous power-on request, active high |
| supply_fail_i | input | 1 | Supply below tolerance, active high |
| pb_n_i | input | 1 | Push-button, active low, asynchronous |
| strobe_i | input | 1 | Watchdog service strobe, asynchronous |
| wd_sel_i | input | 2 | Watchdog period select |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
Some properties are checked on every cycle:
- A supply-fail flag or any other cause is followed by reset.
- Reset is held while the stretch count is below its limit.
- The watchdog count is cleared after a falling edge, after a select change and throughout reset.
- A released button clears the debounced press.

The absolute durations come only from the bench's scenarios: stretch length, each of the three timeouts, and the debounce delay against the 1 ms and 20 ms bounds. So do the acceptance of random strobe trains and the complementary output pair.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Converts a period in milliseconds to a clock-cycle count.
  function automatic int unsigned ms_to_cyc(input int unsigned ms, input int unsigned cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction

  // Bit width that can hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic por_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (por_i) chain_q <= RST_VAL;
        else       chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (por_i) chain_q <= {STAGES{RST_VAL}};
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int unsigned DB_CYC = 16
) (
  input  logic clk,
  input  logic por_i,
  input  logic pb_n_s_i,
  output logic pressed_o
);
  localparam int unsigned CW = sup_pkg::cnt_width(DB_CYC);
  localparam logic [CW-1:0] LAST = CW'(DB_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic          pressed_q;

  always_ff @(posedge clk) begin
    if (por_i || pb_n_s_i) begin
      low_cnt   <= '0;
      pressed_q <= 1'b0;
    end else if (low_cnt == LAST) begin
      pressed_q <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign pressed_o = pressed_q;

  AST_PB_RELEASE: assert property (@(posedge clk) disable iff (por_i)
    pb_n_s_i |=> !pressed_q); // R4
  AST_PB_SHORT_IGNORED: assert property (@(posedge clk) disable iff (por_i)
    (!pb_n_s_i && !pressed_q && low_cnt < LAST) |=> !pressed_q); // R4
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned LIM_S = 600,
  parameter int unsigned LIM_M = 2400,
  parameter int unsigned LIM_L = 4800
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       en_i,
  input  logic       strobe_s_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  localparam int unsigned CW = sup_pkg::cnt_width(LIM_L);

  function automatic logic [CW-1:0] pick_last(input logic [1:0] sel);
    case (sel)
      2'b00:   return CW'(LIM_S - 1);
      2'b01:   return CW'(LIM_M - 1);
      default: return CW'(LIM_L - 1);
    endcase
  endfunction

  logic [CW-1:0] wd_cnt;
  logic          strobe_prev;
  logic [1:0]    sel_q;
  logic          strobe_fall;
  logic          sel_change;
  logic          restart;

  assign strobe_fall = strobe_prev & ~strobe_s_i;
  assign sel_change  = (sel_q != sel_i);
  assign restart     = ~en_i | strobe_fall | sel_change;
  assign expire_o    = ~restart & (wd_cnt == pick_last(sel_i));

  always_ff @(posedge clk) begin
    if (por_i) begin
      wd_cnt      <= '0;
      strobe_prev <= 1'b0;
      sel_q       <= sel_i;
    end else begin
      strobe_prev <= strobe_s_i;
      sel_q       <= sel_i;
      if (restart || expire_o) wd_cnt <= '0;
      else                     wd_cnt <= wd_cnt + 1'b1;
    end
  end

  AST_WD_FALL_RESTART: assert property (@(posedge clk) disable iff (por_i)
    strobe_fall |=> (wd_cnt == '0)); // R7
  AST_WD_SEL_RESTART: assert property (@(posedge clk) disable iff (por_i)
    sel_change |=> (wd_cnt == '0)); // R9
  AST_WD_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (por_i)
    !en_i |=> (wd_cnt == '0)); // R8
  AST_WD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (por_i)
    wd_cnt <= CW'(LIM_L - 1)); // R6
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned STR_CYC = 2440
) (
  input  logic clk,
  input  logic por_i,
  input  logic cause_i,
  output logic rst_o
);
  localparam int unsigned CW = sup_pkg::cnt_width(STR_CYC);
  localparam logic [CW-1:0] LAST = CW'(STR_CYC - 1);

  logic [CW-1:0] hold_cnt;
  logic          rst_q;

  always_ff @(posedge clk) begin
    if (por_i || cause_i) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q) begin
      if (hold_cnt == LAST) rst_q <= 1'b0;
      else                  hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign rst_o = rst_q;

  AST_CAUSE_ASSERTS: assert property (@(posedge clk) disable iff (por_i)
    cause_i |=> rst_q); // R3
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (por_i)
    (rst_q && !cause_i && hold_cnt < LAST) |=> rst_q); // R5
  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (por_i)
    (rst_q && !cause_i && hold_cnt == LAST) |=> !rst_q); // R5
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned CYC_PER_MS  = 50000,
  parameter int unsigned WD_SHORT_MS = 150,
  parameter int unsigned WD_MID_MS   = 600,
  parameter int unsigned WD_LONG_MS  = 1200,
  parameter int unsigned STRETCH_MS  = 610,
  parameter int unsigned DEBOUNCE_MS = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       supply_fail_i,
  input  logic       pb_n_i,
  input  logic       strobe_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o,
  output logic       rst_n_o
);
  localparam int unsigned LIM_S   = sup_pkg::ms_to_cyc(WD_SHORT_MS, CYC_PER_MS);
  localparam int unsigned LIM_M   = sup_pkg::ms_to_cyc(WD_MID_MS,   CYC_PER_MS);
  localparam int unsigned LIM_L   = sup_pkg::ms_to_cyc(WD_LONG_MS,  CYC_PER_MS);
  localparam int unsigned STR_CYC = sup_pkg::ms_to_cyc(STRETCH_MS,  CYC_PER_MS);
  localparam int unsigned DB_CYC  = sup_pkg::ms_to_cyc(DEBOUNCE_MS, CYC_PER_MS);

  logic pb_n_s, strobe_s;
  logic pb_pressed, wd_expire;
  logic any_cause;
  logic rst_int;

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pb_sync (
    .clk(clk), .por_i(por_i), .d_i(pb_n_i), .q_o(pb_n_s));

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_strobe_sync (
    .clk(clk), .por_i(por_i), .d_i(strobe_i), .q_o(strobe_s));

  sup_debounce #(.DB_CYC(DB_CYC)) u_debounce (
    .clk(clk), .por_i(por_i), .pb_n_s_i(pb_n_s), .pressed_o(pb_pressed));

  sup_watchdog #(.LIM_S(LIM_S), .LIM_M(LIM_M), .LIM_L(LIM_L)) u_watchdog (
    .clk(clk), .por_i(por_i), .en_i(~rst_int), .strobe_s_i(strobe_s),
    .sel_i(wd_sel_i), .expire_o(wd_expire));

  assign any_cause = supply_fail_i | pb_pressed | wd_expire;

  sup_stretch #(.STR_CYC(STR_CYC)) u_stretch (
    .clk(clk), .por_i(por_i), .cause_i(any_cause), .rst_o(rst_int));

  assign rst_o   = rst_int;
  assign rst_n_o = ~rst_int;

  AST_FAIL_RESETS: assert property (@(posedge clk) disable iff (por_i)
    supply_fail_i |=> rst_o); // R3
  AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (por_i)
    wd_expire |=> rst_o); // R8
  AST_PRESS_RESETS: assert property (@(posedge clk) disable iff (por_i)
    pb_pressed |=> rst_o); // R4
endmodule

// File: tb/sup_reset_ctrl_bench.sv
module sup_reset_ctrl_bench;
  localparam int CPM = 4;

  logic clk = 1'b0;
  logic por, fail, pb_n, strobe;
  logic [1:0] sel;
  logic rst, rst_n;
  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  always #10 clk = ~clk;

  sup_reset_ctrl #(.CYC_PER_MS(CPM)) u_sup_reset_ctrl (
    .clk(clk), .por_i(por), .supply_fail_i(fail), .pb_n_i(pb_n),
    .strobe_i(strobe), .wd_sel_i(sel), .rst_o(rst), .rst_n_o(rst_n));

  function automatic int exp_timeout(input logic [1:0] s);
    if (s == 2'b00)      return 150 * CPM;
    else if (s == 2'b01) return 600 * CPM;
    else                 return 1200 * CPM;
  endfunction

  function automatic int exp_stretch();
    return 610 * CPM;
  endfunction

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_lvl(input logic lvl, input int limit, output int n);
    n = 0;
    while (rst !== lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  // R2: complementary outputs checked on every sample
  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (rst_n !== ~rst) begin
        errors++;
        $display("FAIL R2: actual rst_n=%b expected %b", rst_n, ~rst);
      end
    end
  end

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int seed_v;
    int t0, str;
    bit seen;
    seed_v = $urandom(17);
    str = exp_stretch();
    por = 1'b1; fail = 1'b0; pb_n = 1'b1; strobe = 1'b0; sel = 2'b00;
    tick(3);
    live = 1'b1;
    check_rng("R1 reset during por", int'(rst), 1, 1);
    por = 1'b0;
    wait_lvl(1'b0, 20000, n);
    check_rng("R1 R5 stretch after por", n, str - 3, str + 3);

    // R6 R7 R8: strobe stuck low, timeout from release with select 00
    wait_lvl(1'b1, 20000, n);
    check_rng("R6 R8 timeout sel 00", n, exp_timeout(2'b00) - 3, exp_timeout(2'b00) + 3);
    sel = 2'b01; strobe = 1'b1;
    wait_lvl(1'b0, 20000, n);
    check_rng("R5 stretch after watchdog", n, str - 3, str + 3);
    wait_lvl(1'b1, 20000, n);
    check_rng("R6 R7 timeout sel 01 strobe high", n, exp_timeout(2'b01) - 3, exp_timeout(2'b01) + 3);
    sel = 2'b10;
    wait_lvl(1'b0, 20000, n);
    wait_lvl(1'b1, 20000, n);
    check_rng("R6 timeout sel 10", n, exp_timeout(2'b10) - 3, exp_timeout(2'b10) + 3);
    sel = 2'b11;
    wait_lvl(1'b0, 20000, n);
    wait_lvl(1'b1, 20000, n);
    check_rng("R6 timeout sel 11", n, exp_timeout(2'b11) - 3, exp_timeout(2'b11) + 3);

    // R7: random falling-edge trains keep reset released
    sel = 2'b00;
    wait_lvl(1'b0, 20000, n);
    t0 = exp_timeout(2'b00);
    seen = 1'b0;
    n = 0;
    while (n < 3 * t0) begin
      int hi_c, lo_c;
      hi_c = 2 + int'($urandom_range(t0 / 4));
      lo_c = 2 + int'($urandom_range(t0 / 4));
      strobe = 1'b1;
      for (int i = 0; i < hi_c; i++) begin @(negedge clk); if (rst) seen = 1'b1; end
      strobe = 1'b0;
      for (int i = 0; i < lo_c; i++) begin @(negedge clk); if (rst) seen = 1'b1; end
      n += hi_c + lo_c;
    end
    check_rng("R7 serviced strobe keeps released", int'(seen), 0, 0);
    wait_lvl(1'b1, 20000, n);
    check_rng("R7 strobe stops then timeout", n, t0 - 8 - t0 / 2, t0 + 3);

    // R9: select change restarts the count
    sel = 2'b01;
    wait_lvl(1'b0, 20000, n);
    tick(300);
    check_rng("R9 no reset before change", int'(rst), 0, 0);
    sel = 2'b10;
    wait_lvl(1'b1, 20000, n);
    check_rng("R9 timeout measured from change", n, exp_timeout(2'b10) - 3, exp_timeout(2'b10) + 3);
    wait_lvl(1'b0, 20000, n);

    // R3: supply-fail
    for (int k = 0; k < 3; k++) begin
      tick(5 + int'($urandom_range(40)));
      fail = 1'b1;
      tick(1);
      check_rng("R3 fail asserts next cycle", int'(rst), 1, 1);
      tick(1 + int'($urandom_range(20)));
      fail = 1'b0;
      wait_lvl(1'b0, 20000, n);
      check_rng("R3 R5 stretch after fail", n, str - 3, str + 3);
    end

    // R4: short button pulses ignored
    for (int k = 0; k < 4; k++) begin
      pb_n = 1'b0;
      tick(1 + int'($urandom_range(CPM - 1)));
      pb_n = 1'b1;
      tick(4 * CPM + 10);
      check_rng("R4 short press ignored", int'(rst), 0, 0);
    end
    pb_n = 1'b0;
    wait_lvl(1'b1, 200, n);
    check_rng("R4 long press delay", n, 4 * CPM, 4 * CPM + 5);
    check_rng("R4 delay within 20 ms", n, 0, 20 * CPM);
    tick(20 * CPM - n);
    pb_n = 1'b1;
    wait_lvl(1'b0, 20000, n);
    check_rng("R4 R5 stretch after button", n, str - 3, str + 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule